// File: doc/BRIEF.md
# Framed Byte-Stream Packet Receiver

This block turns a raw byte stream, one byte per valid cycle, into framed packets. A frame opens with the start byte 0x02. A type byte follows, then a 16-bit payload length sent low byte first. The payload comes next, and the frame closes with a 16-bit check value, also low byte first. Payload bytes leave the block as they arrive, marked with valid and last strobes. The type and length are presented once the header is complete.

At the end of each frame the block pulses either a good indication or an error indication. A separate output holds a code that names the fault. After any fault the receiver returns to hunting and discards every byte until the next 0x02. A frame that stalls part-way for too long is abandoned in the same way. A downstream packet handler uses the type and length, consumes the payload stream, and commits the payload only on the good pulse.

Top module: `pkt_rx`

## Requirements
- R1: While hunting, every byte other than 0x02 is discarded without any output activity; a 0x02 begins a frame.
- R2: The byte after 0x02 is the frame type. The next two bytes are the length, low byte first. `hdr_valid` pulses for one cycle in the cycle the length high byte is accepted, and `frm_type` and `frm_len` then hold those values.
- R3: Each payload byte appears on `pl_data` with a one-cycle `pl_valid`, in arrival order. `pl_last` is high only with the final payload byte. A zero length produces no payload strobe and goes straight to the check bytes.
- R4: The check is CRC-16, polynomial 0x1021, MSB first, with no reflection and no final XOR, starting from `CRC_INIT` (default 0xFFFF). It covers the type byte, both length bytes and the payload. The received value comes low byte first. On a match, `frm_good` pulses for one cycle with the second check byte.
- R5: On a check mismatch, `frm_err` pulses for one cycle with the second check byte, and `err_code` becomes 0x4101.
- R6: A length above `MAX_LEN` (default 0x13FA) raises `frm_err` with `err_code` 0x4100 in the cycle of the length high byte, with no `hdr_valid` and no payload. A length of exactly `MAX_LEN` is accepted.
- R7: After any error or completed frame, the receiver hunts again, and the next 0x02 starts a new frame.
- R8: Inside a frame, `IDLE_LIMIT` consecutive cycles without `in_valid` abort the frame with `frm_err` and `err_code` 0x4102. Shorter gaps are tolerated.
- R9: `frm_good` and `frm_err` are never high together. `err_code` holds its value until the next error. After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte present this cycle |
| in_byte | input | 8 | Input byte |
| hdr_valid | output | 1 | Header accepted pulse |
| frm_type | output | 8 | Type of current frame |
| frm_len | output | 16 | Payload length of current frame |
| pl_valid | output | 1 | Payload byte strobe |
| pl_data | output | 8 | Payload byte |
| pl_last | output | 1 | Final payload byte marker |
| frm_good | output | 1 | Frame passed check pulse |
| frm_err | output | 1 | Frame fault pulse |
| err_code | output | 16 | Code of the most recent fault |

## Verification
The bench targets several boundary cases. It sends a length of exactly `MAX_LEN` and one more: an off-by-one comparison would reject the largest legal frame or pass an oversized one into payload streaming. A zero-length frame catches a receiver that waits for one phantom payload byte and then misreads the check bytes. The bench corrupts the check value and then sends a good frame immediately after, so a receiver that fails to resynchronise loses the following frame. It also stalls a frame past the idle limit, which a missing timer would leave hanging. Finally, it inserts gaps just under the limit, which an eager timer would wrongly abort.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_TYPE,
        ST_LEN_LO,
        ST_LEN_HI,
        ST_DATA,
        ST_CRC_LO,
        ST_CRC_HI
    } rx_state_t;

    localparam logic [7:0]  SOF_BYTE     = 8'h02;
    localparam logic [15:0] ERR_TOO_LONG = 16'h4100;
    localparam logic [15:0] ERR_BAD_CRC  = 16'h4101;
    localparam logic [15:0] ERR_STALL    = 16'h4102;

endpackage

// File: rtl/pkt_crc16.sv
module pkt_crc16 #(
    parameter logic [15:0] POLY = 16'h1021,
    parameter logic [15:0] INIT = 16'hFFFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        restart,
    input  logic        upd,
    input  logic [7:0]  din,
    output logic [15:0] crc
);
    logic [15:0] crc_d, crc_q;

    always_comb begin
        logic [15:0] c;
        c = crc_q;
        if (restart) begin
            c = INIT;
        end else if (upd) begin
            c = c ^ {din, 8'h00};
            for (int b = 0; b < 8; b++) begin
                c = c[15] ? ((c << 1) ^ POLY) : (c << 1);
            end
        end
        crc_d = c;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) crc_q <= INIT;
        else        crc_q <= crc_d;
    end

    assign crc = crc_q;
endmodule

// File: rtl/pkt_idle_timer.sv
module pkt_idle_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic activity,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!armed || activity) cnt_d = '0;
        else                    cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire = armed && !activity && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/pkt_rx.sv
module pkt_rx
    import pkt_rx_pkg::*;
#(
    parameter logic [15:0] MAX_LEN    = 16'h13FA,
    parameter logic [15:0] CRC_INIT   = 16'hFFFF,
    parameter int          IDLE_LIMIT = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [7:0]  in_byte,
    output logic        hdr_valid,
    output logic [7:0]  frm_type,
    output logic [15:0] frm_len,
    output logic        pl_valid,
    output logic [7:0]  pl_data,
    output logic        pl_last,
    output logic        frm_good,
    output logic        frm_err,
    output logic [15:0] err_code
);
    typedef struct packed {
        rx_state_t   st;
        logic [7:0]  ftype;
        logic [15:0] flen;
        logic [15:0] cnt;
        logic [7:0]  crc_lo;
        logic        hdr;
        logic        plv;
        logic [7:0]  pld;
        logic        pll;
        logic        good;
        logic        err;
        logic [15:0] code;
    } rx_regs_t;

    rx_regs_t r_d, r_q;
    logic        crc_restart, crc_upd;
    logic [15:0] crc_val;
    logic        stall;

    pkt_crc16 #(.POLY(16'h1021), .INIT(CRC_INIT)) u_crc (
        .clk(clk), .rst_n(rst_n), .restart(crc_restart),
        .upd(crc_upd), .din(in_byte), .crc(crc_val)
    );

    pkt_idle_timer #(.LIMIT(IDLE_LIMIT)) u_idle (
        .clk(clk), .rst_n(rst_n), .armed(r_q.st != ST_HUNT),
        .activity(in_valid), .expire(stall)
    );

    always_comb begin
        logic [15:0] len_full;
        r_d         = r_q;
        r_d.hdr     = 1'b0;
        r_d.plv     = 1'b0;
        r_d.pll     = 1'b0;
        r_d.good    = 1'b0;
        r_d.err     = 1'b0;
        crc_restart = 1'b0;
        crc_upd     = 1'b0;
        len_full    = {in_byte, r_q.flen[7:0]};

        if (stall) begin
            r_d.st   = ST_HUNT;
            r_d.err  = 1'b1;
            r_d.code = ERR_STALL;
        end else if (in_valid) begin
            unique case (r_q.st)
                ST_HUNT: begin
                    if (in_byte == SOF_BYTE) begin
                        r_d.st      = ST_TYPE;
                        crc_restart = 1'b1;
                    end
                end
                ST_TYPE: begin
                    r_d.ftype = in_byte;
                    crc_upd   = 1'b1;
                    r_d.st    = ST_LEN_LO;
                end
                ST_LEN_LO: begin
                    r_d.flen = {8'h00, in_byte};
                    crc_upd  = 1'b1;
                    r_d.st   = ST_LEN_HI;
                end
                ST_LEN_HI: begin
                    crc_upd  = 1'b1;
                    r_d.flen = len_full;
                    r_d.cnt  = '0;
                    if (len_full > MAX_LEN) begin
                        r_d.st   = ST_HUNT;
                        r_d.err  = 1'b1;
                        r_d.code = ERR_TOO_LONG;
                    end else begin
                        r_d.hdr = 1'b1;
                        r_d.st  = (len_full == 16'h0000) ? ST_CRC_LO : ST_DATA;
                    end
                end
                ST_DATA: begin
                    crc_upd = 1'b1;
                    r_d.plv = 1'b1;
                    r_d.pld = in_byte;
                    r_d.cnt = r_q.cnt + 16'd1;
                    if (r_q.cnt == r_q.flen - 16'd1) begin
                        r_d.pll = 1'b1;
                        r_d.st  = ST_CRC_LO;
                    end
                end
                ST_CRC_LO: begin
                    r_d.crc_lo = in_byte;
                    r_d.st     = ST_CRC_HI;
                end
                ST_CRC_HI: begin
                    r_d.st = ST_HUNT;
                    if ({in_byte, r_q.crc_lo} == crc_val) begin
                        r_d.good = 1'b1;
                    end else begin
                        r_d.err  = 1'b1;
                        r_d.code = ERR_BAD_CRC;
                    end
                end
                default: r_d.st = ST_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{st: ST_HUNT, default: '0};
        else        r_q <= r_d;
    end

    assign hdr_valid = r_q.hdr;
    assign frm_type  = r_q.ftype;
    assign frm_len   = r_q.flen;
    assign pl_valid  = r_q.plv;
    assign pl_data   = r_q.pld;
    assign pl_last   = r_q.pll;
    assign frm_good  = r_q.good;
    assign frm_err   = r_q.err;
    assign err_code  = r_q.code;
endmodule

// File: rtl/pkt_rx_checker.sv
module pkt_rx_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        hdr_valid,
    input logic        pl_valid,
    input logic        pl_last,
    input logic        frm_good,
    input logic        frm_err,
    input logic [15:0] err_code
);
    assert_good_err_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(frm_good && frm_err));

    assert_last_with_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pl_last |-> pl_valid);

    assert_payload_needs_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pl_valid |-> $past(in_valid));

    assert_good_needs_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frm_good |-> $past(in_valid));

    assert_header_needs_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |-> $past(in_valid));

    assert_code_known_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frm_err |-> (err_code == 16'h4100 || err_code == 16'h4101 || err_code == 16'h4102));

    assert_code_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_err |-> $stable(err_code));

    assert_hdr_not_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(hdr_valid && frm_err));
endmodule

bind pkt_rx pkt_rx_checker u_pkt_rx_checker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .hdr_valid(hdr_valid),
    .pl_valid(pl_valid), .pl_last(pl_last), .frm_good(frm_good),
    .frm_err(frm_err), .err_code(err_code)
);

// File: tb/tb_pkt_rx.sv
module tb_pkt_rx;
    localparam logic [15:0] MAXL  = 16'h13FA;
    localparam logic [15:0] CINIT = 16'hFFFF;
    localparam int          IDLE  = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        hdr_valid, pl_valid, pl_last, frm_good, frm_err;
    logic [7:0]  frm_type, pl_data;
    logic [15:0] frm_len, err_code;

    pkt_rx #(.MAX_LEN(MAXL), .CRC_INIT(CINIT), .IDLE_LIMIT(IDLE)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .hdr_valid(hdr_valid), .frm_type(frm_type), .frm_len(frm_len),
        .pl_valid(pl_valid), .pl_data(pl_data), .pl_last(pl_last),
        .frm_good(frm_good), .frm_err(frm_err), .err_code(err_code)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // observations
    int          o_pl, o_pl_bad, o_last, o_last_pos, o_hdr, o_good, o_err, o_both;
    logic [15:0] o_code;
    logic [7:0]  exp_seed;

    function automatic logic [7:0] pat(int i, logic [7:0] seed);
        return 8'(i * 7) ^ seed;
    endfunction

    function automatic logic [15:0] crc_step(logic [15:0] c, logic [7:0] b);
        logic [15:0] x;
        x = c ^ {b, 8'h00};
        for (int k = 0; k < 8; k++) x = x[15] ? ((x << 1) ^ 16'h1021) : (x << 1);
        return x;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_obs(logic [7:0] seed);
        o_pl = 0; o_pl_bad = 0; o_last = 0; o_last_pos = -1;
        o_hdr = 0; o_good = 0; o_err = 0; o_both = 0; o_code = 16'h0;
        exp_seed = seed;
    endtask

    task automatic observe();
        if (pl_valid) begin
            if (pl_data !== pat(o_pl, exp_seed)) o_pl_bad++;
            if (pl_last) begin o_last++; o_last_pos = o_pl; end
            o_pl++;
        end
        if (hdr_valid) o_hdr++;
        if (frm_good) o_good++;
        if (frm_err) begin o_err++; o_code = err_code; end
        if (frm_good && frm_err) o_both++;
    endtask

    task automatic send_byte(logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        @(posedge clk);
        #1;
        observe();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(int n);
        @(negedge clk);
        in_valid = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            observe();
        end
    endtask

    task automatic send_frame(logic [7:0] typ, logic [15:0] len, logic [7:0] seed,
                              bit corrupt, int gap);
        logic [15:0] c;
        c = CINIT;
        send_byte(8'h02);
        send_byte(typ);                 c = crc_step(c, typ);
        if (gap > 0) idle(gap);
        send_byte(len[7:0]);            c = crc_step(c, len[7:0]);
        send_byte(len[15:8]);           c = crc_step(c, len[15:8]);
        for (int i = 0; i < int'(len); i++) begin
            send_byte(pat(i, seed));
            c = crc_step(c, pat(i, seed));
            if (gap > 0 && i == 0) idle(gap);
        end
        send_byte(c[7:0] ^ (corrupt ? 8'h01 : 8'h00));
        if (gap > 0) idle(gap);
        send_byte(c[15:8]);
    endtask

    task automatic t_reset();
        check(!hdr_valid && !pl_valid && !pl_last && !frm_good && !frm_err, "R9 reset pulses", 0, 0);
        check(err_code == 16'h0 && frm_len == 16'h0 && frm_type == 8'h0, "R9 reset values", err_code, 0);
    endtask

    task automatic t_basic();
        clear_obs(8'h11);
        send_frame(8'hA5, 16'd5, 8'h11, 0, 0);
        check(o_hdr == 1, "R2 hdr pulse", o_hdr, 1);
        check(frm_type == 8'hA5, "R2 type", frm_type, 8'hA5);
        check(frm_len == 16'd5, "R2 length", frm_len, 5);
        check(o_pl == 5 && o_pl_bad == 0, "R3 payload", o_pl, 5);
        check(o_last == 1 && o_last_pos == 4, "R3 last position", o_last_pos, 4);
        check(o_good == 1 && o_err == 0, "R4 good frame", o_good, 1);
    endtask

    task automatic t_garbage();
        clear_obs(8'h3C);
        send_byte(8'h55); send_byte(8'hFF); send_byte(8'h00); send_byte(8'h03);
        check(o_pl == 0 && o_hdr == 0 && o_good == 0 && o_err == 0, "R1 garbage ignored", o_pl + o_hdr, 0);
        send_frame(8'h07, 16'h0102, 8'h3C, 0, 0);
        check(frm_len == 16'h0102, "R2 two-byte length", frm_len, 16'h0102);
        check(o_pl == 258 && o_pl_bad == 0 && o_good == 1, "R1 frame after garbage", o_pl, 258);
    endtask

    task automatic t_zero_len();
        clear_obs(8'h00);
        send_frame(8'h44, 16'd0, 8'h00, 0, 0);
        check(o_pl == 0 && o_last == 0, "R3 zero length no payload", o_pl, 0);
        check(o_good == 1 && o_err == 0, "R3 zero length good", o_good, 1);
    endtask

    task automatic t_crc_err();
        clear_obs(8'h21);
        send_frame(8'h10, 16'd3, 8'h21, 1, 0);
        check(o_err == 1 && o_good == 0, "R5 crc error pulse", o_err, 1);
        check(err_code == 16'h4101, "R5 crc code", err_code, 16'h4101);
        clear_obs(8'h22);
        send_frame(8'h11, 16'd4, 8'h22, 0, 0);
        check(o_good == 1 && o_pl == 4 && o_pl_bad == 0, "R7 resync after crc error", o_good, 1);
        check(err_code == 16'h4101, "R9 code held", err_code, 16'h4101);
    endtask

    task automatic t_too_long();
        clear_obs(8'h00);
        send_byte(8'h02); send_byte(8'h01);
        send_byte(8'hFB); send_byte(8'h13);
        check(o_err == 1 && o_hdr == 0, "R6 oversize rejected", o_err, 1);
        check(err_code == 16'h4100, "R6 oversize code", err_code, 16'h4100);
        clear_obs(8'h5A);
        send_frame(8'h02, 16'd2, 8'h5A, 0, 0);
        check(o_good == 1 && o_pl == 2 && o_pl_bad == 0, "R7 resync after length error", o_good, 1);
    endtask

    task automatic t_max_len();
        clear_obs(8'h77);
        send_frame(8'h33, MAXL, 8'h77, 0, 0);
        check(o_hdr == 1 && o_err == 0, "R6 max length accepted", o_err, 0);
        check(o_pl == int'(MAXL) && o_pl_bad == 0 && o_good == 1, "R6 max length payload", o_pl, int'(MAXL));
    endtask

    task automatic t_stall();
        clear_obs(8'h00);
        send_byte(8'h02); send_byte(8'h09);
        idle(IDLE + 8);
        check(o_err == 1, "R8 stall error pulse", o_err, 1);
        check(err_code == 16'h4102, "R8 stall code", err_code, 16'h4102);
        clear_obs(8'h66);
        send_frame(8'h0A, 16'd3, 8'h66, 0, IDLE - 4);
        check(o_err == 0 && o_good == 1 && o_pl == 3, "R8 short gaps tolerated", o_err, 0);
        idle(IDLE + 8);
        check(o_err == 0, "R8 no timer while hunting", o_err, 0);
        check(o_both == 0, "R9 never both pulses", o_both, 0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        t_reset();
        t_basic();
        t_garbage();
        t_zero_len();
        t_crc_err();
        t_too_long();
        t_max_len();
        t_stall();
        done = 1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end
endmodule